// File: doc/BRIEF.md
# Bus Address Window Translator

This block maps byte-wide accesses arriving from an external 16-bit address bus into absolute addresses inside a 4 KiB on-chip memory window. The result can serve directly as the source or destination of a single DMA byte transfer, with no software in the loop. Software programs a 16-bit window base once at startup. After that, each access adds the 12-bit window offset to the base.

The external bus is asynchronous to the block clock. Its address bytes, data byte, direction line and chip-select line pass through a two-stage synchronizer. The rising edge of the synchronized chip-select line starts one access. The offset is the low 12 bits of the external address: the low nibble of the high byte is the page, and the low byte is the index within a 256-byte page.

Only pages 12 through 15 accept writes. A write aimed at a lower page is not rejected. It is steered to a software-programmed dummy byte address, so that protected locations are never touched, and a status flag records the redirection. Each accepted access produces a one-cycle transfer request. Further strobes are ignored until the transfer engine acknowledges.

Top module: `bus_window_xlate`

## Requirements
- R1: After reset, xfer_req, xfer_addr, xfer_rnw, xfer_data and write_redirected are all zero, and the base and dummy registers are zero.
- R2: When cfg_we is high at a clock edge, cfg_wdata is loaded into the window base if cfg_sel is 0, or into the dummy address if cfg_sel is 1.
- R3: A read access (ext_rnw = 1) to any page drives xfer_addr = (base + {ext_addr_hi[3:0], ext_addr_lo}) mod 65536; ext_addr_hi[7:4] has no effect on the result.
- R4: A write access (ext_rnw = 0) whose page ext_addr_hi[3:0] is 12 to 15 drives xfer_addr to the translated address of R3 and sets write_redirected to 0.
- R5: A write access whose page is 0 to 11 drives xfer_addr to the dummy address and sets write_redirected to 1; a read access leaves write_redirected unchanged.
- R6: xfer_req is high for exactly one cycle, asserted at the fourth rising clock edge after ext_cs rises (two synchronizer stages, edge capture, address register).
- R7: xfer_addr, xfer_rnw and xfer_data change only together with xfer_req; xfer_data and xfer_rnw carry the captured ext_data and ext_rnw unchanged, including data values 128 to 143.
- R8: After xfer_req, no further request is issued until xfer_ack has been seen high; chip-select edges during that wait are discarded, not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 1 | Configuration target: 0 base, 1 dummy address |
| cfg_wdata | input | 16 | Configuration write value |
| ext_addr_lo | input | 8 | External address, low byte (asynchronous) |
| ext_addr_hi | input | 8 | External address, high byte (asynchronous) |
| ext_data | input | 8 | External data byte (asynchronous) |
| ext_rnw | input | 1 | External direction: 1 read, 0 write (asynchronous) |
| ext_cs | input | 1 | External chip-select; rising edge starts an access |
| xfer_ack | input | 1 | Transfer engine acknowledge |
| xfer_req | output | 1 | One-cycle transfer request |
| xfer_addr | output | 16 | Absolute memory address for the transfer |
| xfer_rnw | output | 1 | Transfer direction, 1 read |
| xfer_data | output | 8 | Captured data byte for writes |
| write_redirected | output | 1 | The most recent write went to the dummy address |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 12-bit offset and writable pages starting at 12. A 16-bit address lets the bench load a base near 0xFFFF, so the sum wraps. The 12-bit offset gives 16 pages, and the boundary between page 11 and page 12 can be hit directly from both sides. It also lets the bench vary the four upper high-byte bits, which must not affect the result. Random accesses mix both directions, all pages and all data values, and directed cases add the 0x80 to 0x8F data bytes and a chip-select edge arriving while an acknowledge is outstanding.

// File: rtl/bwx_pkg.sv
// Shared types for the bus address window translator.
// Assumes: nothing beyond IEEE 1800-2017.
package bwx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CALC = 2'd1,
        ST_WAIT = 2'd2
    } xl_state_e;
endpackage

// File: rtl/bwx_sync.sv
// Two-flop synchronizer for a bundle of asynchronous inputs.
// Assumes: the bundle bits are held stable around the strobe edge, so bits
// may settle on different cycles without harm; resets to zero.
module bwx_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two back-to-back registers reduce metastability exposure.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;
endmodule

// File: rtl/bwx_cfg_regs.sv
// Software-visible configuration: window base and dummy byte address.
// Assumes: one register written per cycle, selected by cfg_sel.
module bwx_cfg_regs #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] base_addr,
    output logic [ADDR_W-1:0] dummy_addr
);
    // Load the selected register on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr  <= '0;
            dummy_addr <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) dummy_addr <= cfg_wdata;
            else         base_addr  <= cfg_wdata;
        end
    end
endmodule

// File: rtl/bwx_xlate.sv
// Access capture, address translation, page gating and request handshake.
// Assumes: inputs are already synchronized; cs_sync rising starts an access;
// xfer_ack is in the clock domain and is honoured only while waiting.
module bwx_xlate
    import bwx_pkg::*;
#(
    parameter int ADDR_W        = 16,
    parameter int OFFS_W        = 12,
    parameter int BYTE_W        = 8,
    parameter int FIRST_RW_PAGE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] lo_sync,
    input  logic [BYTE_W-1:0] hi_sync,
    input  logic [BYTE_W-1:0] data_sync,
    input  logic              rnw_sync,
    input  logic              cs_sync,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] dummy_addr,
    input  logic              xfer_ack,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_rnw,
    output logic [BYTE_W-1:0] xfer_data,
    output logic              write_redirected
);
    localparam int PAGE_W = OFFS_W - BYTE_W;

    xl_state_e         state_q;
    logic              cs_prev_q;
    logic              cs_rise;
    logic [PAGE_W-1:0] page_q;
    logic [BYTE_W-1:0] index_q;
    logic [BYTE_W-1:0] data_q;
    logic              rnw_q;
    logic [ADDR_W-1:0] trans_addr;
    logic              page_writable;

    assign cs_rise       = cs_sync && !cs_prev_q;
    assign trans_addr    = base_addr + ADDR_W'({page_q, index_q});
    assign page_writable = (int'(page_q) >= FIRST_RW_PAGE);

    // Delay the synchronized chip-select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_prev_q <= 1'b0;
        else        cs_prev_q <= cs_sync;
    end

    // Sequence capture, address registration and acknowledge wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q          <= ST_IDLE;
            page_q           <= '0;
            index_q          <= '0;
            data_q           <= '0;
            rnw_q            <= 1'b0;
            xfer_req         <= 1'b0;
            xfer_addr        <= '0;
            xfer_rnw         <= 1'b0;
            xfer_data        <= '0;
            write_redirected <= 1'b0;
        end else begin
            xfer_req <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cs_rise) begin
                        page_q  <= hi_sync[PAGE_W-1:0];
                        index_q <= lo_sync;
                        data_q  <= data_sync;
                        rnw_q   <= rnw_sync;
                        state_q <= ST_CALC;
                    end
                end
                ST_CALC: begin
                    xfer_req  <= 1'b1;
                    xfer_rnw  <= rnw_q;
                    xfer_data <= data_q;
                    if (rnw_q || page_writable) begin
                        xfer_addr <= trans_addr;
                    end else begin
                        xfer_addr <= dummy_addr;
                    end
                    if (!rnw_q) write_redirected <= !page_writable;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (xfer_ack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_window_xlate.sv
// Top level: synchronizes the external bus, holds configuration and
// translates each access into one DMA byte-transfer request.
// Assumes: external fields are stable while ext_cs rises and for at least
// three clock cycles afterwards.
module bus_window_xlate #(
    parameter int ADDR_W        = 16,
    parameter int OFFS_W        = 12,
    parameter int BYTE_W        = 8,
    parameter int FIRST_RW_PAGE = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic [BYTE_W-1:0] ext_addr_lo,
    input  logic [BYTE_W-1:0] ext_addr_hi,
    input  logic [BYTE_W-1:0] ext_data,
    input  logic              ext_rnw,
    input  logic              ext_cs,
    input  logic              xfer_ack,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic              xfer_rnw,
    output logic [BYTE_W-1:0] xfer_data,
    output logic              write_redirected
);
    localparam int BUNDLE_W = 3 * BYTE_W + 2;

    logic [BUNDLE_W-1:0] bundle_async;
    logic [BUNDLE_W-1:0] bundle_sync;
    logic [BYTE_W-1:0]   lo_s, hi_s, data_s;
    logic                rnw_s, cs_s;
    logic [ADDR_W-1:0]   base_addr, dummy_addr;

    assign bundle_async = {ext_addr_lo, ext_addr_hi, ext_data, ext_rnw, ext_cs};
    assign {lo_s, hi_s, data_s, rnw_s, cs_s} = bundle_sync;

    bwx_sync #(.W(BUNDLE_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (bundle_async),
        .d_sync  (bundle_sync)
    );

    bwx_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .base_addr  (base_addr),
        .dummy_addr (dummy_addr)
    );

    bwx_xlate #(
        .ADDR_W        (ADDR_W),
        .OFFS_W        (OFFS_W),
        .BYTE_W        (BYTE_W),
        .FIRST_RW_PAGE (FIRST_RW_PAGE)
    ) u_xlate (
        .clk              (clk),
        .rst_n            (rst_n),
        .lo_sync          (lo_s),
        .hi_sync          (hi_s),
        .data_sync        (data_s),
        .rnw_sync         (rnw_s),
        .cs_sync          (cs_s),
        .base_addr        (base_addr),
        .dummy_addr       (dummy_addr),
        .xfer_ack         (xfer_ack),
        .xfer_req         (xfer_req),
        .xfer_addr        (xfer_addr),
        .xfer_rnw         (xfer_rnw),
        .xfer_data        (xfer_data),
        .write_redirected (write_redirected)
    );
endmodule

// File: rtl/bwx_chk.sv
// Protocol checker for bus_window_xlate, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module bwx_chk #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_ack,
    input logic              xfer_req,
    input logic [ADDR_W-1:0] xfer_addr,
    input logic              xfer_rnw,
    input logic [BYTE_W-1:0] xfer_data,
    input logic              write_redirected
);
    logic pend_q;

    // Track a request that has not yet been acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q || xfer_req) && !xfer_ack;
    end

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> !xfer_req);

    a_r8_no_req_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> !pend_q);

    a_r7_outputs_move_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |=> (xfer_req || ($stable(xfer_addr) && $stable(xfer_rnw) && $stable(xfer_data))));

    a_r5_read_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |=> ((xfer_req && !xfer_rnw) || $stable(write_redirected)));
endmodule

bind bus_window_xlate bwx_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .xfer_ack         (xfer_ack),
    .xfer_req         (xfer_req),
    .xfer_addr        (xfer_addr),
    .xfer_rnw         (xfer_rnw),
    .xfer_data        (xfer_data),
    .write_redirected (write_redirected)
);

// File: tb/bus_window_xlate_tb.sv
module bus_window_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [7:0]  ext_addr_lo = '0, ext_addr_hi = '0, ext_data = '0;
    logic        ext_rnw = 1'b0, ext_cs = 1'b0, xfer_ack = 1'b0;
    logic        xfer_req;
    logic [15:0] xfer_addr;
    logic        xfer_rnw;
    logic [7:0]  xfer_data;
    logic        write_redirected;

    int errors = 0;
    int checks = 0;
    logic [15:0] base_m = '0, dummy_m = '0;
    logic        redir_m = 1'b0;

    always #4 clk = ~clk;

    bus_window_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ext_addr_lo(ext_addr_lo), .ext_addr_hi(ext_addr_hi),
        .ext_data(ext_data), .ext_rnw(ext_rnw), .ext_cs(ext_cs), .xfer_ack(xfer_ack),
        .xfer_req(xfer_req), .xfer_addr(xfer_addr), .xfer_rnw(xfer_rnw),
        .xfer_data(xfer_data), .write_redirected(write_redirected)
    );

    function automatic logic [15:0] exp_addr(logic [15:0] b, logic [7:0] hi, logic [7:0] lo, logic rnw, logic [15:0] d);
        if (!rnw && hi[3:0] < 4'd12) return d;
        return b + {4'h0, hi[3:0], lo};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(logic sel, logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) dummy_m = v; else base_m = v;
    endtask

    // One access; checks request timing, address, flag and data.
    task automatic access(logic [7:0] hi, logic [7:0] lo, logic [7:0] d, logic rnw, string req);
        logic [15:0] ea;
        @(negedge clk);
        ext_addr_hi = hi; ext_addr_lo = lo; ext_data = d; ext_rnw = rnw; ext_cs = 1'b1;
        ea = exp_addr(base_m, hi, lo, rnw, dummy_m);
        if (!rnw) redir_m = (hi[3:0] < 4'd12);
        repeat (3) @(negedge clk);
        chk({"R6 early ", req}, {31'd0, xfer_req}, 32'd0);
        @(negedge clk);
        chk({"R6 req ", req}, {31'd0, xfer_req}, 32'd1);
        chk({"R3/R4/R5 addr ", req}, {16'd0, xfer_addr}, {16'd0, ea});
        chk({"R5 flag ", req}, {31'd0, write_redirected}, {31'd0, redir_m});
        chk({"R7 data/rnw ", req}, {23'd0, xfer_rnw, xfer_data}, {23'd0, rnw, d});
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        chk({"R6 one cycle ", req}, {31'd0, xfer_req}, 32'd0);
        ext_cs = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 outputs", {5'd0, xfer_req, xfer_addr, xfer_rnw, xfer_data, write_redirected}, 32'd0);
        // R1: base and dummy start at zero
        access(8'h00, 8'h34, 8'h11, 1'b1, "R1 base zero read");
        access(8'h03, 8'h21, 8'h22, 1'b0, "R1 dummy zero write");
        // R2: configuration
        cfg_write(1'b0, 16'h2000);
        cfg_write(1'b1, 16'h1FFF);
        access(8'h05, 8'h10, 8'h33, 1'b1, "R2 R3 read page5");
        access(8'hF5, 8'h10, 8'h33, 1'b1, "R3 upper nibble ignored");
        access(8'h0B, 8'hFF, 8'h44, 1'b0, "R5 page11 write");
        access(8'h04, 8'h00, 8'h55, 1'b1, "R5 read keeps flag");
        access(8'h0C, 8'h00, 8'h80, 1'b0, "R4 page12 write 0x80");
        access(8'h0F, 8'hFF, 8'h8F, 1'b0, "R4 page15 write 0x8F R7");
        access(8'h07, 8'h07, 8'h88, 1'b1, "R5 read low page R7");
        // R3: wrap of base + offset
        cfg_write(1'b0, 16'hFF80);
        access(8'h0E, 8'hC0, 8'h81, 1'b0, "R3 wrap");
        // R8: edges while waiting for ack are discarded
        @(negedge clk);
        ext_addr_hi = 8'h0D; ext_addr_lo = 8'h01; ext_rnw = 1'b1; ext_cs = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 first req", {31'd0, xfer_req}, 32'd1);
        ext_cs = 1'b0;
        repeat (4) @(negedge clk);
        ext_addr_lo = 8'h99; ext_cs = 1'b1;
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (xfer_req) seen++;
            end
            xfer_ack = 1'b1;
            @(negedge clk);
            xfer_ack = 1'b0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (xfer_req) seen++;
            end
            chk("R8 no req while busy", seen, 0);
            chk("R8 addr held", {16'd0, xfer_addr}, {16'd0, base_m + 16'h0D01});
        end
        ext_cs = 1'b0;
        repeat (3) @(negedge clk);
        // Random mix
        for (int n = 0; n < 60; n++) begin
            if (n % 15 == 0) cfg_write(1'($urandom % 2), 16'($urandom));
            access(8'($urandom), 8'($urandom), 8'($urandom), 1'($urandom % 2), "R3/R4/R5/R7 random");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule